// File: doc/BRIEF.md
# Dual-Clock Sample FIFO with Programmable Level Flags

This block buffers sample words between two unrelated clock domains. A producer, such as a converter front end, pushes words on its own write clock with an active-low write strobe. A consumer pulls the words out in arrival order on a separate read clock with an active-low read strobe. The capture flow is to run the producer until the almost-full flag drops, stop it, read out the whole block, and then pulse the master reset before the next capture.

The write-side logic computes full, almost-full and half-full from its own pointer and a synchronized copy of the read pointer. The read-side logic computes empty and almost-empty from its own pointer and a synchronized copy of the write pointer. Each side has its own threshold register, and both registers reload 63 on master reset. Pointers cross between the domains in Gray code. A write into a full buffer and a read from an empty buffer change nothing, and each such attempt sets a sticky error bit on its own side.

Top module: `xclk_fifo`

## Requirements
- R1: Once master reset `mrst_n` (active low, asynchronous) is released, the outputs settle to `empty_n`=0, `full_n`=1, `ae_n`=0, `af_n`=1, `half_full`=0, `wr_err`=0 and `rd_err`=0.
- R2: Words leave in the order they were accepted. A read is accepted on a `rclk` rising edge with `ren_n`=0 while `empty_n`=1, and its word appears on `rdata` at that same edge.
- R3: `full_n` is 0 exactly when DEPTH (default 4096) words are stored. A write attempted while `full_n`=0 changes neither the contents nor the count, and it sets `wr_err`, which stays at 1 until master reset. One read from a full buffer returns `full_n` to 1.
- R4: `empty_n` is 0 exactly when no word is stored. A read attempted while `empty_n`=0 leaves `rdata` and the count unchanged, and it sets `rd_err`, which stays at 1 until master reset.
- R5: `half_full` is 1 exactly when more than DEPTH/2 words are stored, that is 2049 or more at the default depth.
- R6: `ae_n` is 0 exactly when the stored count is less than or equal to the read-side offset n.
- R7: `af_n` is 0 exactly when the stored count is greater than or equal to DEPTH minus the write-side offset m.
- R8: Both offsets are 63 after master reset. Offset n is loaded from `aeo_val` on a `rclk` edge with `aeo_we`=1. Offset m is loaded from `afo_val` on a `wclk` edge with `afo_we`=1.
- R9: A master reset pulse issued while words are stored discards them: both pointers return to zero, and the next word written is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write strobe, active low |
| wdata | input | DW (18) | Word to store |
| afo_we | input | 1 | Load strobe for the almost-full offset (wclk domain) |
| afo_val | input | AW (12) | New almost-full offset m |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| af_n | output | 1 | Low when the count is at least DEPTH-m |
| half_full | output | 1 | High when the count exceeds DEPTH/2 |
| wr_err | output | 1 | Sticky flag: a write was attempted while full |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read strobe, active low |
| rdata | output | DW (18) | Registered output word |
| aeo_we | input | 1 | Load strobe for the almost-empty offset (rclk domain) |
| aeo_val | input | AW (12) | New almost-empty offset n |
| empty_n | output | 1 | Low when the buffer holds no words |
| ae_n | output | 1 | Low when the count is at most n |
| rd_err | output | 1 | Sticky flag: a read was attempted while empty |

## Verification
Directed single-word steps walk the count across every flag boundary: n and n+1 for almost-empty (first with the default offset, then with a programmed one), 2048 and 2049 for half-full, DEPTH-m-1 and DEPTH-m for almost-full, and the full and empty edges. These steps separate a wrong comparison from a bound that is off by one. Overrun and underrun bursts at the two edges show whether a blocked access leaks into the contents, the pointers or the output register. Random interleaved bursts on the two unrelated clocks exercise the Gray pointer crossing, and a data or ordering error appears as a mismatch against the reference queue. A master reset with data still stored tells apart a design that really clears its pointers and offsets from one that only clears its flags.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  localparam int unsigned GW = 32;

  function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/xf_sync2.sv
`timescale 1ns/1ps
module xf_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/xf_ram.sv
`timescale 1ns/1ps
module xf_ram #(
  parameter int AW = 12,
  parameter int DW = 18
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/xf_wr_side.sv
`timescale 1ns/1ps
module xf_wr_side
  import xfifo_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DEF_OFF = 63
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen_n,
  input  logic          off_we,
  input  logic [AW-1:0] off_val,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          mem_we,
  output logic          full_n,
  output logic          af_n,
  output logic          half_full,
  output logic          err
);
  localparam int          PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
  localparam logic [PW-1:0] HALF  = PW'(1 << (AW - 1));

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rbin_s, cnt;
  logic [AW-1:0] off_q, off_d;
  logic          err_q, err_d, full, accept;

  always_comb begin
    rbin_s  = PW'(gray2bin(GW'(rgray_s)));
    cnt     = wbin_q - rbin_s;
    full    = (cnt == DEPTH);
    accept  = !wen_n && !full;
    wbin_d  = wbin_q + PW'(accept);
    wgray_d = PW'(bin2gray(GW'(wbin_d)));
    off_d   = off_we ? off_val : off_q;
    err_d   = err_q | (!wen_n && full);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      off_q   <= AW'(DEF_OFF);
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        wbin_q  <= wbin_d;
        wgray_q <= wgray_d;
      end
      if (off_we) off_q <= off_d;
      err_q <= err_d;
    end
  end

  assign wgray     = wgray_q;
  assign waddr     = wbin_q[AW-1:0];
  assign mem_we    = accept;
  assign full_n    = !full;
  assign af_n      = !(cnt >= (DEPTH - {1'b0, off_q}));
  assign half_full = (cnt > HALF);
  assign err       = err_q;

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    cnt <= DEPTH); // R3
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!full_n && !wen_n) |=> $stable(wgray)); // R3
  AST_WERR_STICKY: assert property (@(posedge wclk) disable iff (!wrst_n)
    err |=> err); // R3
  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0(wgray ^ $past(wgray))); // R2
endmodule

// File: rtl/xf_rd_side.sv
`timescale 1ns/1ps
module xf_rd_side
  import xfifo_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DEF_OFF = 63
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren_n,
  input  logic          off_we,
  input  logic [AW-1:0] off_val,
  input  logic [AW:0]   wgray_s,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          mem_re,
  output logic          empty_n,
  output logic          ae_n,
  output logic          err
);
  localparam int            PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s, cnt;
  logic [AW-1:0] off_q, off_d;
  logic          err_q, err_d, empty, accept;

  always_comb begin
    wbin_s  = PW'(gray2bin(GW'(wgray_s)));
    cnt     = wbin_s - rbin_q;
    empty   = (cnt == '0);
    accept  = !ren_n && !empty;
    rbin_d  = rbin_q + PW'(accept);
    rgray_d = PW'(bin2gray(GW'(rbin_d)));
    off_d   = off_we ? off_val : off_q;
    err_d   = err_q | (!ren_n && empty);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      off_q   <= AW'(DEF_OFF);
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
      end
      if (off_we) off_q <= off_d;
      err_q <= err_d;
    end
  end

  assign rgray   = rgray_q;
  assign raddr   = rbin_q[AW-1:0];
  assign mem_re  = accept;
  assign empty_n = !empty;
  assign ae_n    = !(cnt <= {1'b0, off_q});
  assign err     = err_q;

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
    cnt <= DEPTH); // R4
  AST_EMPTY_BLOCKS_READ: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!empty_n && !ren_n) |=> $stable(rgray)); // R4
  AST_RERR_STICKY: assert property (@(posedge rclk) disable iff (!rrst_n)
    err |=> err); // R4
  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rrst_n)
    $onehot0(rgray ^ $past(rgray))); // R2
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int AW      = 12,
  parameter int DW      = 18,
  parameter int DEF_OFF = 63
) (
  input  logic          mrst_n,
  input  logic          wclk,
  input  logic          wen_n,
  input  logic [DW-1:0] wdata,
  input  logic          afo_we,
  input  logic [AW-1:0] afo_val,
  output logic          full_n,
  output logic          af_n,
  output logic          half_full,
  output logic          wr_err,
  input  logic          rclk,
  input  logic          ren_n,
  output logic [DW-1:0] rdata,
  input  logic          aeo_we,
  input  logic [AW-1:0] aeo_val,
  output logic          empty_n,
  output logic          ae_n,
  output logic          rd_err
);
  localparam int PW = AW + 1;

  logic          wrst_n, rrst_n, mem_we, mem_re;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;

  xf_sync2 #(.W(1)) i_wrst (.clk(wclk), .rst_n(mrst_n), .d(1'b1), .q(wrst_n));
  xf_sync2 #(.W(1)) i_rrst (.clk(rclk), .rst_n(mrst_n), .d(1'b1), .q(rrst_n));

  xf_sync2 #(.W(PW)) i_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  xf_sync2 #(.W(PW)) i_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  xf_wr_side #(.AW(AW), .DEF_OFF(DEF_OFF)) i_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wen_n(wen_n),
    .off_we(afo_we), .off_val(afo_val), .rgray_s(rgray_s),
    .wgray(wgray), .waddr(waddr), .mem_we(mem_we),
    .full_n(full_n), .af_n(af_n), .half_full(half_full), .err(wr_err)
  );

  xf_rd_side #(.AW(AW), .DEF_OFF(DEF_OFF)) i_rd (
    .rclk(rclk), .rrst_n(rrst_n), .ren_n(ren_n),
    .off_we(aeo_we), .off_val(aeo_val), .wgray_s(wgray_s),
    .rgray(rgray), .raddr(raddr), .mem_re(mem_re),
    .empty_n(empty_n), .ae_n(ae_n), .err(rd_err)
  );

  xf_ram #(.AW(AW), .DW(DW)) i_ram (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .re(mem_re), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/test_xclk_fifo.sv
`timescale 1ns/1ps
module test_xclk_fifo;
  localparam int AW    = 12;
  localparam int DW    = 18;
  localparam int DEPTH = 1 << AW;

  logic          mrst_n, wclk, rclk, wen_n, ren_n, afo_we, aeo_we;
  logic [DW-1:0] wdata, rdata;
  logic [AW-1:0] afo_val, aeo_val;
  logic          full_n, af_n, half_full, wr_err, empty_n, ae_n, rd_err;

  xclk_fifo #(.AW(AW), .DW(DW), .DEF_OFF(63)) i_xclk_fifo (
    .mrst_n(mrst_n), .wclk(wclk), .wen_n(wen_n), .wdata(wdata),
    .afo_we(afo_we), .afo_val(afo_val), .full_n(full_n), .af_n(af_n),
    .half_full(half_full), .wr_err(wr_err), .rclk(rclk), .ren_n(ren_n),
    .rdata(rdata), .aeo_we(aeo_we), .aeo_val(aeo_val), .empty_n(empty_n),
    .ae_n(ae_n), .rd_err(rd_err)
  );

  initial wclk = 1'b0;
  always #2.5 wclk = ~wclk;
  initial rclk = 1'b0;
  always #3.6 rclk = ~rclk;

  int unsigned checks = 0, failures = 0;
  bit          done = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_rd;
  bit          have_exp = 0, exp_werr = 0, exp_rerr = 0;
  int          n_off = 63, m_off = 63;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit e_full_n(int c);  return !(c == DEPTH);         endfunction
  function automatic bit e_empty_n(int c); return !(c == 0);             endfunction
  function automatic bit e_hf(int c);      return c > DEPTH / 2;         endfunction
  function automatic bit e_ae_n(int c);    return !(c <= n_off);         endfunction
  function automatic bit e_af_n(int c);    return !(c >= DEPTH - m_off); endfunction

  task automatic settle(input string tag);
    int c;
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
    @(negedge wclk);
    c = q.size();
    chk(full_n == e_full_n(c), "R3", {tag, " full_n"}, full_n, e_full_n(c));
    chk(empty_n == e_empty_n(c), "R4", {tag, " empty_n"}, empty_n, e_empty_n(c));
    chk(half_full == e_hf(c), "R5", {tag, " half_full"}, half_full, e_hf(c));
    chk(ae_n == e_ae_n(c), "R6", {tag, " ae_n"}, ae_n, e_ae_n(c));
    chk(af_n == e_af_n(c), "R7", {tag, " af_n"}, af_n, e_af_n(c));
    chk(wr_err == exp_werr, "R3", {tag, " wr_err"}, wr_err, exp_werr);
    chk(rd_err == exp_rerr, "R4", {tag, " rd_err"}, rd_err, exp_rerr);
  endtask

  task automatic wr_burst(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge wclk);
      wdata = DW'($urandom);
      wen_n = 1'b0;
      if (full_n) q.push_back(wdata);
      else exp_werr = 1;
    end
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic rd_burst(input int k);
    bit last_acc = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge rclk);
      if (have_exp)
        chk(rdata == exp_rd, last_acc ? "R2" : "R4", "rdata", rdata, exp_rd);
      ren_n = 1'b0;
      last_acc = empty_n;
      if (empty_n) begin
        exp_rd = q.pop_front();
        have_exp = 1;
      end else exp_rerr = 1;
    end
    @(negedge rclk);
    ren_n = 1'b1;
    if (have_exp)
      chk(rdata == exp_rd, last_acc ? "R2" : "R4", "rdata", rdata, exp_rd);
  endtask

  task automatic set_offs(input int n, input int m);
    @(negedge rclk); aeo_we = 1'b1; aeo_val = AW'(n);
    @(negedge rclk); aeo_we = 1'b0;
    @(negedge wclk); afo_we = 1'b1; afo_val = AW'(m);
    @(negedge wclk); afo_we = 1'b0;
    n_off = n; m_off = m;
  endtask

  task automatic master_reset();
    @(negedge wclk); mrst_n = 1'b0;
    repeat (3) @(negedge rclk);
    mrst_n = 1'b1;
    q.delete();
    have_exp = 0; exp_werr = 0; exp_rerr = 0;
    n_off = 63; m_off = 63;
  endtask

  initial begin
    #750000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mrst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; wdata = '0;
    afo_we = 1'b0; aeo_we = 1'b0; afo_val = '0; aeo_val = '0;
    repeat (8) @(negedge wclk);
    mrst_n = 1'b1;
    settle("R1 after reset");

    wr_burst(1);   settle("one word");
    rd_burst(1);   settle("one word read");       // R2

    wr_burst(63);  settle("R8 default n at 63");  // R6
    wr_burst(1);   settle("R8 default n at 64");

    set_offs(5, 10);                              // R8 programmed
    rd_burst(58);  settle("n=5 at 6");
    rd_burst(1);   settle("n=5 at 5");            // R6

    wr_burst(2048 - 5); settle("R5 at 2048");
    wr_burst(1);        settle("R5 at 2049");
    wr_burst(DEPTH - 10 - 1 - 2049); settle("R7 at DEPTH-m-1");
    wr_burst(1);        settle("R7 at DEPTH-m");
    wr_burst(10);       settle("R3 full");
    wr_burst(20);       settle("R3 overrun ignored");
    rd_burst(1);        settle("R3 one read from full");
    rd_burst(DEPTH - 1); settle("drained");
    rd_burst(5);        settle("R4 underrun ignored");

    for (int r = 0; r < 30; r++) begin
      fork
        wr_burst($urandom_range(0, 300));
        rd_burst($urandom_range(0, 300));
      join
      settle("random mix");
    end

    wr_burst(100);
    master_reset();
    settle("R9 reset with data");
    wr_burst(63);  settle("R9 R8 n back to 63");
    wr_burst(1);   settle("R9 R8 n back to 63 plus one");
    rd_burst(64);  settle("R9 data after reset");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule